// File: doc/BRIEF.md
# Task Lane Instruction Sequencer

This block runs the instruction list of one task lane. A global controller raises a start level. The sequencer then walks a small instruction ROM from address 0. For each instruction it first drives the task-memory read address of each source operand, one per cycle, and tells the selected function block when to capture each word and in which operand slot. It then fires the block once and waits for its completion. Finally it writes the returned result to the destination address named in the instruction.

The function blocks never see an address. All operand steering and write-back addressing comes from the instruction word, so a block only needs an opcode select, capture strobes, a start pulse and a done/result/fault return. When the list ends, the sequencer raises its done level. It holds that level until the global controller drops the start level, and only then re-arms. A fault flag returned by any block during a run is collected into a sticky output that is cleared when the next run is accepted.

Top module: `lane_seq`

## Requirements
- R1: After reset, done_o, fault_o, mem_re_o, mem_we_o, fb_capture_o and fb_start_o are low. With go_i low the block stays idle and issues no memory read or write.
- R2: An instruction word is, from MSB to LSB: opcode (OPC_W bits), operand count (2 bits, 0 to 3), source address A, source address B, source address C, destination address (AW bits each), and a last-instruction flag in bit 0.
- R3: For an operand count N, the block issues exactly N read cycles back to back, at addresses A, B, C in that order. One cycle after each read it pulses fb_capture_o, with fb_slot_o equal to 0, 1, 2 in turn. With N = 0 it issues no read.
- R4: After the final capture, the block gives exactly one fb_start_o pulse per instruction. fb_op_o carries that instruction's opcode and does not change from the pulse until the write-back.
- R5: The cycle after fb_done_i is seen in the waiting phase, the block performs one write of fb_result_i to the destination address. Each instruction writes exactly once.
- R6: Instructions execute in ROM order, starting at address 0. The next instruction is fetched only after the previous write, so a later instruction reads the result of an earlier one. The list ends after the first instruction whose last flag is set.
- R7: The instruction at the highest ROM address ends the list even when its last flag is clear.
- R8: done_o rises after the last write and stays high while go_i stays high, with no further activity. It falls in the cycle after go_i is sampled low. A new run starts only when go_i is high again after that.
- R9: fault_o is the OR of fb_fault_i over all completions in a run. It stays set after the run and while idle, and it is cleared when the next run is accepted.
- R10: fb_done_i asserted outside the waiting phase has no effect: no write occurs and done_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start level from the global controller |
| done_o | output | 1 | Instruction list completed |
| fault_o | output | 1 | Sticky OR of block fault flags for the current/last run |
| rom_addr_o | output | PC_W | Instruction ROM address (combinational read) |
| rom_data_i | input | INSN_W | Instruction word at rom_addr_o |
| mem_re_o | output | 1 | Task-memory read strobe (data one cycle later) |
| mem_raddr_o | output | AW | Task-memory read address |
| mem_we_o | output | 1 | Task-memory write strobe |
| mem_waddr_o | output | AW | Task-memory write address |
| mem_wdata_o | output | DW | Task-memory write data |
| fb_op_o | output | OPC_W | Function-block select / opcode |
| fb_capture_o | output | 1 | Capture read data into an operand slot |
| fb_slot_o | output | 2 | Operand slot for the current capture |
| fb_start_o | output | 1 | One-cycle execute pulse |
| fb_done_i | input | 1 | Function-block completion |
| fb_result_i | input | DW | Function-block result, valid with fb_done_i |
| fb_fault_i | input | 1 | Function-block fault, valid with fb_done_i |

## Verification
A wrong operand index or a bad state step shows up within one instruction. The symptom is a read at the wrong address, a capture in the wrong slot, or a result that differs from the value computed from the preloaded memory. Chained programs, where each instruction consumes the previous result, make any ordering or fetch error visible in the final memory contents. A broken program counter or end condition shows as a wrong number of writes or a done level that never arrives. A broken handshake shows as done_o not tracking go_i in the cycle after the drop.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;
  localparam int unsigned NSRC  = 3;
  localparam int unsigned CNT_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_SETTLE,
    ST_FIRE,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/lane_seq_fsm.sv
module lane_seq_fsm
  import lane_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       fetch_zero_i,
  input  logic       opnd_last_i,
  input  logic       list_end_i,
  input  logic       fb_done_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:   if (go_i) state_n = ST_FETCH;
      ST_FETCH:  state_n = fetch_zero_i ? ST_FIRE : ST_READ;
      ST_READ:   if (opnd_last_i) state_n = ST_SETTLE;
      ST_SETTLE: state_n = ST_FIRE;
      ST_FIRE:   state_n = ST_WAIT;
      ST_WAIT:   if (fb_done_i) state_n = ST_WRITE;
      ST_WRITE:  state_n = list_end_i ? ST_DONE : ST_FETCH;
      ST_DONE:   if (!go_i) state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lane_seq_ptr.sv
module lane_seq_ptr
  import lane_seq_pkg::*;
#(
  parameter int unsigned PC_W   = 4,
  parameter int unsigned INSN_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_i,
  input  logic              go_i,
  input  logic [INSN_W-1:0] rom_data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [INSN_W-1:0] ir_o,
  output logic [CNT_W-1:0]  idx_o
);
  logic [PC_W-1:0]   pc_q, pc_n;
  logic [INSN_W-1:0] ir_q;
  logic [CNT_W-1:0]  idx_q, idx_n;
  logic              pc_en, ir_en, idx_en;

  always_comb begin
    pc_en  = 1'b0;
    pc_n   = pc_q;
    idx_en = 1'b0;
    idx_n  = idx_q;
    if (state_i == ST_IDLE && go_i) begin
      pc_en = 1'b1;
      pc_n  = '0;
    end else if (state_i == ST_WRITE) begin
      pc_en = 1'b1;
      pc_n  = pc_q + PC_W'(1);
    end
    if (state_i == ST_FETCH) begin
      idx_en = 1'b1;
      idx_n  = '0;
    end else if (state_i == ST_READ) begin
      idx_en = 1'b1;
      idx_n  = idx_q + CNT_W'(1);
    end
  end

  assign ir_en = (state_i == ST_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      idx_q <= '0;
      ir_q  <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_n;
      if (idx_en) idx_q <= idx_n;
      if (ir_en)  ir_q  <= rom_data_i;
    end
  end

  assign pc_o  = pc_q;
  assign ir_o  = ir_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/lane_seq_wb.sv
module lane_seq_wb
  import lane_seq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_e       state_i,
  input  logic             go_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             fb_done_i,
  input  logic [DW-1:0]    fb_result_i,
  input  logic             fb_fault_i,
  output logic             cap_o,
  output logic [CNT_W-1:0] slot_o,
  output logic [DW-1:0]    res_o,
  output logic             fault_o
);
  logic             cap_q;
  logic [CNT_W-1:0] slot_q;
  logic [DW-1:0]    res_q;
  logic             fault_q, fault_n;
  logic             rd_now, res_en, flt_clr, flt_en;

  assign rd_now  = (state_i == ST_READ);
  assign res_en  = (state_i == ST_WAIT) && fb_done_i;
  assign flt_clr = (state_i == ST_IDLE) && go_i;
  assign flt_en  = flt_clr || res_en;

  always_comb begin
    fault_n = fault_q;
    if (flt_clr)     fault_n = 1'b0;
    else if (res_en) fault_n = fault_q | fb_fault_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      slot_q  <= '0;
      res_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cap_q <= rd_now;
      if (rd_now) slot_q  <= idx_i;
      if (res_en) res_q   <= fb_result_i;
      if (flt_en) fault_q <= fault_n;
    end
  end

  assign cap_o   = cap_q;
  assign slot_o  = slot_q;
  assign res_o   = res_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/lane_seq.sv
module lane_seq
  import lane_seq_pkg::*;
#(
  parameter  int unsigned DW     = 16,
  parameter  int unsigned AW     = 4,
  parameter  int unsigned PC_W   = 4,
  parameter  int unsigned OPC_W  = 4,
  localparam int unsigned INSN_W = OPC_W + CNT_W + (NSRC + 1) * AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [PC_W-1:0]   rom_addr_o,
  input  logic [INSN_W-1:0] rom_data_i,
  output logic              mem_re_o,
  output logic [AW-1:0]     mem_raddr_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [OPC_W-1:0]  fb_op_o,
  output logic              fb_capture_o,
  output logic [CNT_W-1:0]  fb_slot_o,
  output logic              fb_start_o,
  input  logic              fb_done_i,
  input  logic [DW-1:0]     fb_result_i,
  input  logic              fb_fault_i
);
  localparam int unsigned DST_LSB = 1;
  localparam int unsigned CNT_LSB = (NSRC + 1) * AW + 1;
  localparam int unsigned OPC_LSB = CNT_LSB + CNT_W;
  localparam int unsigned NSLOT   = 1 << CNT_W;

  seq_state_e        state;
  logic [PC_W-1:0]   pc;
  logic [INSN_W-1:0] ir;
  logic [CNT_W-1:0]  idx;
  logic [CNT_W-1:0]  nopnd;
  logic              fetch_zero, opnd_last, list_end;
  logic [AW-1:0]     src_addr [NSLOT];
  logic [DW-1:0]     res;

  // Source address fields; slot k (0 = A) sits at (NSRC-k)*AW+1.
  for (genvar k = 0; k < NSLOT; k++) begin : g_src
    if (k < NSRC) begin : g_fld
      assign src_addr[k] = ir[(NSRC - k) * AW + 1 +: AW];
    end else begin : g_pad
      assign src_addr[k] = '0;
    end
  end

  assign nopnd      = ir[CNT_LSB +: CNT_W];
  assign fetch_zero = (rom_data_i[CNT_LSB +: CNT_W] == '0);
  assign opnd_last  = (idx == nopnd - CNT_W'(1));
  assign list_end   = ir[0] | (&pc);

  lane_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go_i),
    .fetch_zero_i (fetch_zero),
    .opnd_last_i  (opnd_last),
    .list_end_i   (list_end),
    .fb_done_i    (fb_done_i),
    .state_o      (state)
  );

  lane_seq_ptr #(
    .PC_W   (PC_W),
    .INSN_W (INSN_W)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state),
    .go_i       (go_i),
    .rom_data_i (rom_data_i),
    .pc_o       (pc),
    .ir_o       (ir),
    .idx_o      (idx)
  );

  lane_seq_wb #(
    .DW (DW)
  ) u_wb (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state),
    .go_i        (go_i),
    .idx_i       (idx),
    .fb_done_i   (fb_done_i),
    .fb_result_i (fb_result_i),
    .fb_fault_i  (fb_fault_i),
    .cap_o       (fb_capture_o),
    .slot_o      (fb_slot_o),
    .res_o       (res),
    .fault_o     (fault_o)
  );

  assign rom_addr_o  = pc;
  assign mem_re_o    = (state == ST_READ);
  assign mem_raddr_o = src_addr[idx];
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_waddr_o = ir[DST_LSB +: AW];
  assign mem_wdata_o = res;
  assign fb_op_o     = ir[OPC_LSB +: OPC_W];
  assign fb_start_o  = (state == ST_FIRE);
  assign done_o      = (state == ST_DONE);
endmodule

// File: rtl/lane_seq_chk.sv
module lane_seq_chk #(
  parameter int unsigned OPC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_i,
  input logic             done_o,
  input logic             mem_re_o,
  input logic             mem_we_o,
  input logic             fb_capture_o,
  input logic             fb_start_o,
  input logic             fb_done_i,
  input logic [OPC_W-1:0] fb_op_o
);
  a_r3_capture_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> fb_capture_o);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re_o, fb_start_o, mem_we_o}));

  a_r4_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    fb_start_o |=> $stable(fb_op_o));

  // R10: a write is only ever preceded by a completion
  a_r5_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(fb_done_i));

  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && go_i) |=> done_o);

  a_r8_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !go_i) |=> !done_o);
endmodule

bind lane_seq lane_seq_chk #(.OPC_W(OPC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .go_i         (go_i),
  .done_o       (done_o),
  .mem_re_o     (mem_re_o),
  .mem_we_o     (mem_we_o),
  .fb_capture_o (fb_capture_o),
  .fb_start_o   (fb_start_o),
  .fb_done_i    (fb_done_i),
  .fb_op_o      (fb_op_o)
);

// File: tb/lane_seq_bench.sv
module lane_seq_bench;
  localparam int DW = 16, AW = 4, PC_W = 4, OPC_W = 4;
  localparam int IW = OPC_W + 2 + 4 * AW + 1;
  localparam int NV = 6;
  // {opcode[37:34], count[33:32], A[31:28], B[27:24], C[23:20], dst[19:16], expected[15:0]}
  localparam logic [37:0] VEC [NV] = '{
    {4'd0, 2'd2, 4'd1, 4'd2,  4'd0, 4'd9,  16'd11},
    {4'd0, 2'd3, 4'd3, 4'd4,  4'd5, 4'd0,  16'd39},
    {4'd1, 2'd2, 4'd0, 4'd15, 4'd0, 4'd15, 16'd47},
    {4'd0, 2'd1, 4'd6, 4'd0,  4'd0, 4'd7,  16'd19},
    {4'd1, 2'd3, 4'd2, 4'd2,  4'd8, 4'd3,  16'd25},
    {4'd0, 2'd0, 4'd1, 4'd1,  4'd1, 4'd4,  16'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic done, fault, mem_re, mem_we, fb_cap, fb_start;
  logic fb_done = 1'b0, fb_fault = 1'b0;
  logic [DW-1:0] fb_res = '0, wdata, rdata_q = '0;
  logic [PC_W-1:0] rom_addr;
  logic [IW-1:0] rom [16];
  logic [IW-1:0] rom_data;
  logic [AW-1:0] raddr, waddr;
  logic [OPC_W-1:0] fb_op;
  logic [1:0] fb_slot;
  logic [DW-1:0] mem [16];

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, cap_cnt = 0, start_cnt = 0, slot_err = 0;
  logic [AW-1:0] rd_log [64];
  logic [OPC_W-1:0] last_op = '0, cur_op = '0;
  logic [DW-1:0] acc = '0, xacc = '0;
  logic [1:0] ncap = '0;
  logic busy = 1'b0;
  logic [OPC_W-1:0] lat = '0;
  int stray_req = 0, stray_seen = 0;

  always #4 clk = ~clk;

  assign rom_data = rom[rom_addr];

  lane_seq u_lane_seq (
    .clk(clk), .rst_n(rst_n), .go_i(go), .done_o(done), .fault_o(fault),
    .rom_addr_o(rom_addr), .rom_data_i(rom_data),
    .mem_re_o(mem_re), .mem_raddr_o(raddr), .mem_we_o(mem_we),
    .mem_waddr_o(waddr), .mem_wdata_o(wdata),
    .fb_op_o(fb_op), .fb_capture_o(fb_cap), .fb_slot_o(fb_slot),
    .fb_start_o(fb_start), .fb_done_i(fb_done), .fb_result_i(fb_res),
    .fb_fault_i(fb_fault)
  );

  // Task memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) begin
      mem[waddr] <= wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_re) begin
      rdata_q <= mem[raddr];
      rd_log[rd_cnt[5:0]] <= raddr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  // Function block model: opcode 0 sum, 1 xor, 2 sum with fault; latency opcode+1
  always @(posedge clk) begin
    fb_done <= 1'b0;
    if (fb_cap) begin
      if (fb_slot != ncap) slot_err <= slot_err + 1;
      acc <= acc + rdata_q;
      xacc <= xacc ^ rdata_q;
      ncap <= ncap + 2'd1;
      cap_cnt <= cap_cnt + 1;
    end
    if (fb_start) begin
      busy <= 1'b1;
      lat <= fb_op;
      cur_op <= fb_op;
      last_op <= fb_op;
      start_cnt <= start_cnt + 1;
    end else if (busy) begin
      if (lat == '0) begin
        busy <= 1'b0;
        fb_done <= 1'b1;
        fb_res <= (cur_op == 4'd1) ? xacc : acc;
        fb_fault <= (cur_op == 4'd2);
        acc <= '0;
        xacc <= '0;
        ncap <= '0;
      end else begin
        lat <= lat - 4'd1;
      end
    end else if (stray_req != stray_seen) begin
      stray_seen <= stray_req;
      fb_done <= 1'b1;
      fb_res <= 16'hDEAD;
      fb_fault <= 1'b1;
    end
  end

  function automatic logic [IW-1:0] mk(input logic [3:0] op, input logic [1:0] n,
      input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
      input logic [3:0] d, input logic lst);
    return {op, n, a, b, c, d, lst};
  endfunction

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic preload();
    for (int i = 0; i < 16; i++) mem[i] <= DW'(i * 3 + 1);
    @(negedge clk);
  endtask

  task automatic fill_rom_default();
    for (int i = 0; i < 16; i++) rom[i] = mk(4'd0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd14, 1'b1);
  endtask

  task automatic run_to_done(input string req);
    int n = 0;
    go = 1'b1;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(done, req, done, 1);
  endtask

  task automatic release_go();
    go = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0, r0, c0, s0, e0, n;
    fill_rom_default();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check({done, fault, mem_re, mem_we, fb_cap, fb_start} == 6'b0, "R1 reset outputs",
          {done, fault, mem_re, mem_we, fb_cap, fb_start}, 0);
    repeat (5) @(negedge clk);
    check(wr_cnt == 0 && rd_cnt == 0, "R1 idle without go", wr_cnt + rd_cnt, 0);

    // Vector table: single-instruction programs (R2, R3, R4, R5)
    for (int v = 0; v < NV; v++) begin
      logic [37:0] t;
      logic [3:0] src [3];
      t = VEC[v];
      src[0] = t[31:28]; src[1] = t[27:24]; src[2] = t[23:20];
      preload();
      rom[0] = mk(t[37:34], t[33:32], t[31:28], t[27:24], t[23:20], t[19:16], 1'b1);
      w0 = wr_cnt; r0 = rd_cnt; c0 = cap_cnt; s0 = start_cnt; e0 = slot_err;
      run_to_done("R8 done after list");
      check(mem[t[19:16]] == t[15:0], "R2 R5 result at destination", mem[t[19:16]], t[15:0]);
      check(wr_cnt - w0 == 1, "R5 one write", wr_cnt - w0, 1);
      check(start_cnt - s0 == 1 && last_op == t[37:34], "R4 one start with opcode",
            last_op, t[37:34]);
      check(rd_cnt - r0 == int'(t[33:32]) && cap_cnt - c0 == int'(t[33:32]),
            "R3 read and capture count", rd_cnt - r0, t[33:32]);
      check(slot_err == e0, "R3 slot order", slot_err - e0, 0);
      for (int k = 0; k < int'(t[33:32]); k++)
        check(rd_log[(r0 + k) % 64] == src[k], "R3 read address order",
              rd_log[(r0 + k) % 64], src[k]);
      release_go();
    end

    // R6: chained program, order and stop at last flag
    preload();
    fill_rom_default();
    rom[0] = mk(4'd0, 2'd2, 4'd1, 4'd2, 4'd0, 4'd10, 1'b0);
    rom[1] = mk(4'd0, 2'd2, 4'd10, 4'd10, 4'd0, 4'd11, 1'b0);
    rom[2] = mk(4'd1, 2'd2, 4'd11, 4'd0, 4'd0, 4'd12, 1'b1);
    rom[3] = mk(4'd0, 2'd1, 4'd0, 4'd0, 4'd0, 4'd13, 1'b1);
    w0 = wr_cnt;
    run_to_done("R6 chain done");
    check(mem[10] == 16'd11, "R6 first result", mem[10], 11);
    check(mem[11] == 16'd22, "R6 dependent result", mem[11], 22);
    check(mem[12] == 16'd23, "R6 third result", mem[12], 23);
    check(mem[13] == 16'd40 && wr_cnt - w0 == 3, "R6 stop at last flag", wr_cnt - w0, 3);

    // R8: hold while go high, release after go low, no restart while low
    s0 = start_cnt;
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R8 done held", done, 1);
    check(wr_cnt - w0 == 3 && start_cnt == s0, "R8 no activity while done", wr_cnt - w0, 3);
    go = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R8 done falls after go low", done, 0);
    repeat (5) @(negedge clk);
    check(wr_cnt - w0 == 3, "R8 no restart while go low", wr_cnt - w0, 3);
    run_to_done("R8 restart on new go");
    check(wr_cnt - w0 == 6, "R8 rerun writes", wr_cnt - w0, 6);
    release_go();

    // R7: no last flag anywhere, ends at top ROM address
    preload();
    for (int i = 0; i < 16; i++) rom[i] = mk(4'd0, 2'd0, 4'd0, 4'd0, 4'd0, 4'(i), 1'b0);
    w0 = wr_cnt;
    run_to_done("R7 end of ROM done");
    check(wr_cnt - w0 == 16, "R7 writes through whole ROM", wr_cnt - w0, 16);
    check(mem[15] == 16'd0, "R7 last address executed", mem[15], 0);
    release_go();

    // R9: sticky fault
    preload();
    fill_rom_default();
    rom[0] = mk(4'd2, 2'd1, 4'd1, 4'd0, 4'd0, 4'd5, 1'b0);
    rom[1] = mk(4'd0, 2'd1, 4'd2, 4'd0, 4'd0, 4'd6, 1'b1);
    run_to_done("R9 fault run done");
    check(fault == 1'b1, "R9 fault sticky over clean op", fault, 1);
    check(mem[6] == 16'd7, "R9 later op still executed", mem[6], 7);
    release_go();
    repeat (3) @(negedge clk);
    check(fault == 1'b1, "R9 fault held while idle", fault, 1);
    rom[0] = mk(4'd0, 2'd1, 4'd1, 4'd0, 4'd0, 4'd5, 1'b1);
    go = 1'b1;
    @(negedge clk);
    check(fault == 1'b0, "R9 fault cleared on trigger", fault, 0);
    run_to_done("R9 clean run done");
    check(fault == 1'b0, "R9 clean run no fault", fault, 0);
    release_go();

    // R10: stray completion while idle
    w0 = wr_cnt;
    stray_req = stray_req + 1;
    n = 0;
    repeat (5) @(negedge clk);
    check(wr_cnt == w0 && done == 1'b0, "R10 stray done ignored", wr_cnt - w0, 0);
    check(fault == 1'b0, "R10 stray fault ignored", fault, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule